// File: doc/BRIEF.md
# Streaming Sample Burst Writer

This block sits between a sampling front end and a bus-master request port. Incoming sample words are collected into a staging register until one full burst of payload is present. The block then presents a single memory write request carrying that payload and a destination address. Destinations come from a small table of buffer base addresses that software loads through a word-wide register port. Bursts fill each buffer from offset zero upward. When a buffer is full, the block moves to the next table entry, and after the last entry it returns to the first. A one-cycle completion pulse marks every finished buffer.

Software starts the stream with a run bit and must also set a bus-master enable bit, because no request is presented without it. A pattern mode swaps the incoming samples for a counter sequence, so the whole path can be checked against known data. A sticky overflow flag records any sample that arrived while a finished burst was still waiting for acceptance. That sample is dropped.

The controller has three states. IDLE moves to FILL when the run bit is set. FILL moves to ISSUE when the last word of a burst is captured, and moves back to IDLE when the run bit is cleared, which discards the partial burst. ISSUE moves to FILL when the request is accepted with run still set, and moves to IDLE when the request is accepted with run cleared.

Top module: `dmaw_top`

## Requirements
- R1: After reset, req_valid and buf_done are low, and the control, command, status and pointer registers all read as zero.
- R2: Register map by word address. Address 0 is control (bit 0 run, bit 1 pattern mode). Address 1 is command (bit 2 bus-master enable). Address 2 is status (bit 0 overflow, bits 5:4 current table entry). Addresses 4 to 7 are the pointer table entries 0 to 3. Control, command and pointers read back what was written.
- R3: req_valid is never high while the bus-master enable bit is clear. Clearing the bit with a burst pending drops req_valid, and setting it again presents the same request.
- R4: While the run bit is clear, samples are ignored and no request is issued.
- R5: A burst is 32 words of 32 bits, and the word captured i-th occupies req_payload bits [32i+31:32i]. req_valid rises in the cycle after the 32nd word is captured and holds, with address and payload stable, until req_ready is seen.
- R6: The request address is the current entry's base plus an offset. The offset advances by 128 on each accepted burst and is 0 for the first burst of every buffer.
- R7: The table entry advances after the final burst of a buffer, wraps from 3 to 0, and is readable in the status register.
- R8: buf_done is a one-cycle pulse in the cycle after the final burst of a buffer is accepted, and is low at all other times.
- R9: In pattern mode, payload words come from a 32-bit counter that starts at 0 when streaming starts and increments once per captured word. The sample data is ignored.
- R10: A sample that arrives while a burst is pending and not accepted in that cycle sets the sticky overflow bit and does not alter the pending payload. Writing 1 to status bit 0 clears the bit.
- R11: Clearing the run bit lets a pending burst still be issued. After that, the block is idle, the table entry and offset return to entry 0 and offset 0, and the pattern counter returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| smp_valid | input | 1 | Sample word present |
| smp_data | input | 32 | Sample word |
| req_valid | output | 1 | Write request pending |
| req_ready | input | 1 | Write request accepted in this cycle when req_valid is high |
| req_addr | output | 32 | Byte address of the burst |
| req_payload | output | 1024 | Burst payload, word 0 in the low bits |
| buf_done | output | 1 | One-cycle pulse when a buffer is complete |

## Verification
The packing path is driven with several generated word sequences: ascending counts, a constant all-ones word, all zeros, alternating top-bit words and a mixed stride. Any swapped, duplicated or lost word position in the payload therefore appears as a mismatch. These bursts span a buffer boundary, which tells the offset step apart from the table-entry step and places the completion pulse on exactly one accepted burst. The pattern-mode run uses all-ones input samples, so a counter value that leaks the sample data stands out. A long pattern run that crosses all four entries shows the wrap back to entry 0. Directed sequences then hold a request unaccepted while samples keep arriving, toggle the enable bit, and stop the stream in mid-request.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ISSUE = 2'd2
    } dmaw_state_t;

    localparam int REG_CTRL     = 0;
    localparam int REG_CMD      = 1;
    localparam int REG_STAT     = 2;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_PAT_BIT = 1;
    localparam int CMD_BME_BIT  = 2;
    localparam int STAT_OVF_BIT = 0;
    localparam int STAT_IDX_LSB = 4;

endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
    import dmaw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_PTR = 4,
    parameter int IDX_W   = 2,
    parameter int REG_AW  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_AW-1:0]         addr,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    input  logic                      ovf_evt,
    input  logic [IDX_W-1:0]          cur_idx,
    output logic                      run,
    output logic                      pat_mode,
    output logic                      bme,
    output logic                      ovf_flag,
    output logic [NUM_PTR*ADDR_W-1:0] base_flat
);

    logic              run_q, pat_q, bme_q, ovf_q;
    logic [ADDR_W-1:0] ptr_q [NUM_PTR];
    logic              sel_tab;
    logic [IDX_W-1:0]  sel_idx;
    logic              stat_clr;

    assign sel_tab  = addr[REG_AW-1];
    assign sel_idx  = addr[IDX_W-1:0];
    assign stat_clr = wr_en && (addr == REG_AW'(REG_STAT)) && wr_data[STAT_OVF_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pat_q <= 1'b0;
            bme_q <= 1'b0;
            for (int i = 0; i < NUM_PTR; i++) ptr_q[i] <= '0;
        end else if (wr_en) begin
            if (sel_tab) begin
                ptr_q[sel_idx] <= wr_data[ADDR_W-1:0];
            end else if (addr == REG_AW'(REG_CTRL)) begin
                run_q <= wr_data[CTRL_RUN_BIT];
                pat_q <= wr_data[CTRL_PAT_BIT];
            end else if (addr == REG_AW'(REG_CMD)) begin
                bme_q <= wr_data[CMD_BME_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (ovf_evt)  ovf_q <= 1'b1;
        else if (stat_clr) ovf_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        if (sel_tab) begin
            rd_data = 32'(ptr_q[sel_idx]);
        end else if (addr == REG_AW'(REG_CTRL)) begin
            rd_data[CTRL_RUN_BIT] = run_q;
            rd_data[CTRL_PAT_BIT] = pat_q;
        end else if (addr == REG_AW'(REG_CMD)) begin
            rd_data[CMD_BME_BIT] = bme_q;
        end else if (addr == REG_AW'(REG_STAT)) begin
            rd_data[STAT_OVF_BIT]               = ovf_q;
            rd_data[STAT_IDX_LSB +: IDX_W]      = cur_idx;
        end
    end

    generate
        for (genvar g = 0; g < NUM_PTR; g++) begin : g_base
            assign base_flat[g*ADDR_W +: ADDR_W] = ptr_q[g];
        end
    endgenerate

    assign run      = run_q;
    assign pat_mode = pat_q;
    assign bme      = bme_q;
    assign ovf_flag = ovf_q;

endmodule

// File: rtl/dmaw_pack.sv
module dmaw_pack #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic                    clr,
    input  logic                    pat_mode,
    input  logic [WORD_W-1:0]       smp_data,
    output logic                    cap_last,
    output logic [WORDS*WORD_W-1:0] payload
);

    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [CNT_W-1:0]        wcnt_q;
    logic [WORD_W-1:0]       pat_q;
    logic [WORDS*WORD_W-1:0] stage_q;
    logic [WORD_W-1:0]       word_in;
    logic                    at_last;

    assign at_last  = (wcnt_q == CNT_W'(WORDS - 1));
    assign cap_last = cap && at_last;
    assign word_in  = pat_mode ? pat_q : smp_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            pat_q  <= '0;
        end else if (clr) begin
            wcnt_q <= '0;
            pat_q  <= '0;
        end else if (cap) begin
            wcnt_q <= at_last ? '0 : wcnt_q + CNT_W'(1);
            pat_q  <= pat_q + WORD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   stage_q <= '0;
        else if (cap) stage_q[wcnt_q*WORD_W +: WORD_W] <= word_in;
    end

    assign payload = stage_q;

endmodule

// File: rtl/dmaw_ctrl.sv
module dmaw_ctrl
    import dmaw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_PTR     = 4,
    parameter int IDX_W       = 2,
    parameter int BUF_BYTES   = 2097152,
    parameter int BURST_BYTES = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      bme,
    input  logic                      smp_valid,
    input  logic                      cap_last,
    input  logic                      req_ready,
    input  logic [NUM_PTR*ADDR_W-1:0] base_flat,
    output logic                      req_valid,
    output logic [ADDR_W-1:0]         req_addr,
    output logic                      cap_en,
    output logic                      clr,
    output logic                      ovf_evt,
    output logic                      buf_done,
    output logic [IDX_W-1:0]          cur_idx
);

    localparam int OFF_W    = $clog2(BUF_BYTES);
    localparam int LAST_OFF = BUF_BYTES - BURST_BYTES;

    dmaw_state_t       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic              done_q;
    logic              accept;
    logic              buf_end;

    assign accept  = req_valid && req_ready;
    assign buf_end = (off_q == OFF_W'(LAST_OFF));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_FILL;
            ST_FILL: begin
                if (!run)          state_d = ST_IDLE;
                else if (cap_last) state_d = ST_ISSUE;
            end
            ST_ISSUE: if (accept) state_d = run ? ST_FILL : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_valid = (state_q == ST_ISSUE) && bme;
        cap_en    = run && ((state_q == ST_FILL) ||
                            ((state_q == ST_ISSUE) && req_ready && bme));
        clr       = (state_d == ST_IDLE);
        ovf_evt   = (state_q == ST_ISSUE) && smp_valid && !(req_ready && bme);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            off_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept && buf_end;
            if (clr) begin
                idx_q <= '0;
                off_q <= '0;
            end else if (accept) begin
                if (buf_end) begin
                    off_q <= '0;
                    idx_q <= (idx_q == IDX_W'(NUM_PTR - 1)) ? '0 : idx_q + IDX_W'(1);
                end else begin
                    off_q <= off_q + OFF_W'(BURST_BYTES);
                end
            end
        end
    end

    assign req_addr = base_flat[idx_q*ADDR_W +: ADDR_W] + ADDR_W'(off_q);
    assign buf_done = done_q;
    assign cur_idx  = idx_q;

endmodule

// File: rtl/dmaw_top.sv
module dmaw_top #(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int NUM_PTR     = 4,
    parameter int BURST_BYTES = 128,
    parameter int BUF_BYTES   = 2097152,
    localparam int WORDS      = BURST_BYTES * 8 / WORD_W,
    localparam int PAY_W      = WORDS * WORD_W,
    localparam int IDX_W      = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
    localparam int REG_AW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [PAY_W-1:0]  req_payload,
    output logic              buf_done
);

    logic                      run, pat_mode, bme, ovf_flag, ovf_evt;
    logic                      cap_en, cap, cap_last, clr;
    logic [IDX_W-1:0]          cur_idx;
    logic [NUM_PTR*ADDR_W-1:0] base_flat;

    assign cap = cap_en && smp_valid;

    dmaw_regs #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .ovf_evt(ovf_evt),
        .cur_idx(cur_idx), .run(run), .pat_mode(pat_mode), .bme(bme),
        .ovf_flag(ovf_flag), .base_flat(base_flat)
    );

    dmaw_pack #(
        .WORD_W(WORD_W), .WORDS(WORDS)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .cap(cap), .clr(clr), .pat_mode(pat_mode),
        .smp_data(smp_data), .cap_last(cap_last), .payload(req_payload)
    );

    dmaw_ctrl #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W),
        .BUF_BYTES(BUF_BYTES), .BURST_BYTES(BURST_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .bme(bme), .smp_valid(smp_valid),
        .cap_last(cap_last), .req_ready(req_ready), .base_flat(base_flat),
        .req_valid(req_valid), .req_addr(req_addr), .cap_en(cap_en), .clr(clr),
        .ovf_evt(ovf_evt), .buf_done(buf_done), .cur_idx(cur_idx)
    );

endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk #(
    parameter int ADDR_W = 32,
    parameter int PAY_W  = 1024,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [PAY_W-1:0]  req_payload,
    input logic              buf_done,
    input logic              bme,
    input logic              ovf_flag
);

    logic stat_clr;
    assign stat_clr = reg_wr && (reg_addr == REG_AW'(2)) && reg_wdata[0];

    assert_bme_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> bme);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_payload)));

    assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> $past(req_valid && req_ready));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !stat_clr) |=> ovf_flag);

endmodule

bind dmaw_top dmaw_chk #(
    .ADDR_W(ADDR_W), .PAY_W(PAY_W), .REG_AW(REG_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_payload(req_payload), .buf_done(buf_done),
    .bme(bme), .ovf_flag(ovf_flag)
);

// File: tb/sim_dmaw_top.sv
module sim_dmaw_top;

    localparam int CLK_NS  = 10;
    localparam int BUF     = 512;
    localparam int BPB     = BUF / 128;
    localparam int WORDS   = 32;
    localparam int PAY_W   = 1024;
    localparam int WD_CYC  = 20000;
    localparam int NVEC    = 6;
    // each entry: {seed, step}; word i of the burst is seed + i*step
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h0000_0001, 32'h0000_0001},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000},
        {32'h7FFF_FFFF, 32'h8000_0000},
        {32'hA5A5_0000, 32'h0101_0101},
        {32'h1234_5678, 32'h0F0F_1111}
    };

    logic              clk, rst_n;
    logic              reg_wr;
    logic [2:0]        reg_addr;
    logic [31:0]       reg_wdata, reg_rdata;
    logic              smp_valid;
    logic [31:0]       smp_data;
    logic              req_valid, req_ready, buf_done;
    logic [31:0]       req_addr;
    logic [PAY_W-1:0]  req_payload;

    int errors = 0;
    int checks = 0;

    dmaw_top #(.BUF_BYTES(BUF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_payload(req_payload), .buf_done(buf_done)
    );

    initial clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] base_of(input int e);
        return 32'h1000_0000 * (e + 1);
    endfunction

    function automatic logic [PAY_W-1:0] mk(input logic [31:0] seed, input logic [31:0] step);
        logic [PAY_W-1:0] v;
        for (int i = 0; i < WORDS; i++) v[i*32 +: 32] = seed + step * i;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic push_burst(input logic [31:0] seed, input logic [31:0] step);
        for (int i = 0; i < WORDS; i++) push(seed + step * i);
    endtask

    task automatic take();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", WD_CYC);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [PAY_W-1:0] held;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        smp_valid = 1'b0; smp_data = '0; req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 0);
        chk(buf_done == 1'b0, "R1 buf_done", 64'(buf_done), 0);
        reg_read(3'd0, rd); chk(rd == 0, "R1 ctrl", 64'(rd), 0);
        reg_read(3'd2, rd); chk(rd == 0, "R1 status", 64'(rd), 0);
        reg_read(3'd4, rd); chk(rd == 0, "R1 ptr0", 64'(rd), 0);

        for (int e = 0; e < 4; e++) reg_write(3'(4 + e), base_of(e));
        reg_read(3'd6, rd); chk(rd == base_of(2), "R2 ptr2 readback", 64'(rd), 64'(base_of(2)));

        // R4 idle samples ignored
        reg_write(3'd1, 32'h4);
        for (int i = 0; i < 40; i++) push(32'h5555_0000 + 32'(i));
        chk(req_valid == 1'b0, "R4 no request while idle", 64'(req_valid), 0);

        reg_write(3'd0, 32'h1);
        reg_read(3'd0, rd); chk(rd == 32'h1, "R2 ctrl readback", 64'(rd), 1);
        reg_read(3'd1, rd); chk(rd == 32'h4, "R2 cmd readback", 64'(rd), 4);

        // vector table: R5 packing, R6 address, R8 completion
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] ea;
            push_burst(VECS[k][63:32], VECS[k][31:0]);
            ea = base_of((k / BPB) % 4) + 32'((k % BPB) * 128);
            chk(req_valid == 1'b1, "R5 req_valid after 32 words", 64'(req_valid), 1);
            chk(req_addr == ea, "R6 burst address", 64'(req_addr), 64'(ea));
            chk(req_payload == mk(VECS[k][63:32], VECS[k][31:0]), "R5 payload",
                req_payload[63:0], mk(VECS[k][63:32], VECS[k][31:0]) >> 0);
            take();
            chk(buf_done == ((k % BPB) == BPB - 1), "R8 done pulse", 64'(buf_done),
                64'((k % BPB) == BPB - 1));
            chk(req_valid == 1'b0, "R5 req drops after accept", 64'(req_valid), 0);
            if (k == BPB - 1) begin
                @(negedge clk);
                chk(buf_done == 1'b0, "R8 pulse one cycle", 64'(buf_done), 0);
                reg_read(3'd2, rd);
                chk(rd[5:4] == 2'd1, "R7 status entry", 64'(rd[5:4]), 1);
            end
        end

        // R10 overflow
        push_burst(32'h77, 32'h3);
        held = req_payload;
        push(32'hDEAD_BEEF);
        reg_read(3'd2, rd); chk(rd[0] == 1'b1, "R10 overflow set", 64'(rd[0]), 1);
        chk(req_payload == held, "R10 payload kept", req_payload[63:0], held[63:0]);
        reg_write(3'd2, 32'h1);
        reg_read(3'd2, rd); chk(rd[0] == 1'b0, "R10 overflow cleared", 64'(rd[0]), 0);

        // R3 bus-master gating
        reg_write(3'd1, 32'h0);
        chk(req_valid == 1'b0, "R3 gated off", 64'(req_valid), 0);
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R3 stays off", 64'(req_valid), 0);
        reg_write(3'd1, 32'h4);
        chk(req_valid == 1'b1, "R3 request returns", 64'(req_valid), 1);
        chk(req_addr == base_of(1) + 32'd256, "R6 addr after regate", 64'(req_addr),
            64'(base_of(1) + 32'd256));

        // R11 stop with pending burst
        reg_write(3'd0, 32'h0);
        chk(req_valid == 1'b1, "R11 pending kept", 64'(req_valid), 1);
        take();
        for (int i = 0; i < 40; i++) push(32'(i));
        chk(req_valid == 1'b0, "R11 idle after stop", 64'(req_valid), 0);
        reg_read(3'd2, rd); chk(rd[5:4] == 2'd0, "R11 entry reset", 64'(rd[5:4]), 0);

        // R9 pattern mode
        reg_write(3'd0, 32'h3);
        push_burst(32'hFFFF_FFFF, 32'h0);
        chk(req_addr == base_of(0), "R11 restart at entry 0", 64'(req_addr), 64'(base_of(0)));
        chk(req_payload == mk(32'd0, 32'd1), "R9 pattern first burst", req_payload[63:0], 64'h1_0000_0000);
        take();
        push_burst(32'hFFFF_FFFF, 32'h0);
        chk(req_payload == mk(32'd32, 32'd1), "R9 pattern second burst", req_payload[63:0], 64'h21_0000_0020);
        chk(req_addr == base_of(0) + 32'd128, "R6 pattern addr", 64'(req_addr), 64'(base_of(0) + 32'd128));
        take();

        // R7 wrap through all entries
        for (int b = 0; b < 14; b++) begin
            push_burst(32'h0, 32'h0);
            take();
        end
        push_burst(32'h0, 32'h0);
        chk(req_addr == base_of(0), "R7 wrap to entry 0", 64'(req_addr), 64'(base_of(0)));
        chk(req_payload[31:0] == 32'd512, "R9 counter continues", 64'(req_payload[31:0]), 512);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule